// File: doc/BRIEF.md
# Camera Vertical Timing Synchroniser

This block keeps the vertical timing of an interlaced camera aligned with whatever reference is present. It watches one sync input, one horizontal reference input and a sync-type strap, and from that pattern decides whether it runs on internal timing, locks to a composite sync stream, or locks to separate vertical and horizontal drives. A per-line tick from the horizontal timing logic clocks a field line counter. That counter drives an active-low vertical drive pulse and an odd/even field flag.

When no external reference is present, the counter free-runs in 2:1 interlace. A 525-line frame alternates 263-line and 262-line fields, and a 625-line frame alternates 313-line and 312-line fields. In composite mode the block takes the vertical interval out of the sync stream. It restarts the field a fixed number of lines after the end of that interval, and that number depends on the line standard. In separate-drive mode it restarts the field one line after the external vertical pulse ends. It also takes the field parity from where in the line that edge falls. The external indicator output is high while the block is locked to either external reference.

Top module: `vsm_top`

## Requirements
- R1: While reset is held and just after it, `ext_sync_o` is 0, `field_odd_o` is 1 and the line counter is 0, so `vd_n_o` is 0.
- R2: In internal mode the counter advances once per `line_tick` and wraps after the field length. With `std_625`=0 an odd field (`field_odd_o`=1) is 263 lines and an even field is 262 lines. With `std_625`=1 they are 313 and 312 lines. `field_odd_o` toggles at each wrap. `vd_n_o` is 0 for the first `VD_W_LINES` (default 3) lines of every field.
- R3: With `sync_sel`=0, a low phase of `sync_in` that lasts at least `VR_MIN_CLK` clocks is a vertical interval, and its rising end is the reference point. The field restarts (`vd_n_o` falls) on the 259th `line_tick` after that point when `std_625`=0, and on the 309th when `std_625`=1. `field_odd_o` is unchanged. Shorter low phases are ignored.
- R4: With `sync_sel`=1 and HD active, a falling edge of a high `sync_in` pulse restarts the field on the next `line_tick`. HD is active when `hd_in` has had a rising edge within the last two line ticks.
- R5: In separate-drive mode, a `sync_in` high pulse that spans fewer than two `line_tick`s is ignored, and the line counter continues.
- R6: On a separate-drive restart, `field_odd_o` becomes 1 if `line_half` was 0 (first half of the line) when the edge was seen, and becomes 0 if `line_half` was 1.
- R7: `ext_sync_o` goes to 1 on the first accepted composite or separate-drive reference event.
- R8: If no reference event is accepted for 525 line ticks (`std_625`=0) or 625 line ticks (`std_625`=1), `ext_sync_o` returns to 0 on that tick.
- R9: Separate-drive lock holds when the vertical period is longer than a field. A pulse that arrives 400 lines after the previous one still restarts the field and keeps `ext_sync_o` at 1.
- R10: With `sync_sel`=1 and HD inactive, vertical pulses are ignored. `ext_sync_o` stays 0 and the counter is not restarted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_tick | input | 1 | One-cycle pulse per line from horizontal timing |
| line_half | input | 1 | High during the second half of each line |
| sync_in | input | 1 | Composite sync (active low) or vertical drive (active high) |
| hd_in | input | 1 | External horizontal drive reference |
| sync_sel | input | 1 | 0: composite-sync pattern, 1: separate-drive pattern |
| std_625 | input | 1 | 0: 525-line standard, 1: 625-line standard |
| ext_sync_o | output | 1 | High while locked to an external reference |
| vd_n_o | output | 1 | Vertical drive, low at the start of each field |
| field_odd_o | output | 1 | High in odd field, low in even field |

## Verification
On every cycle, the embedded properties check four things. The line counter moves only on a line tick. The field flag changes only when the counter sits at line 0. A composite event and a vertical-drive event never fire together. The external indicator rises only after an accepted event and falls only on a line tick. The exact restart distances (259 and 309 lines, and one line) can only be shown by the directed scenarios, which count ticks against the output. The same holds for the field lengths in each standard, the parity taken from the line half, the rejection of short pulses and of pulses without HD, the timeout back to internal timing, and lock over a long vertical period.

// File: rtl/vsm_pkg.sv
package vsm_pkg;

    // Active synchronisation source
    typedef enum logic [1:0] {
        VSM_INT   = 2'd0,
        VSM_CSYNC = 2'd1,
        VSM_VDHD  = 2'd2
    } vsm_mode_e;

endpackage

// File: rtl/vsm_sync_probe.sv
// Input conditioning: synchronises sync/HD, extracts the vertical interval
// from composite sync, qualifies vertical drive pulses and tracks HD activity.
module vsm_sync_probe #(
    parameter int VR_MIN_CLK = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_tick,
    input  logic line_half,
    input  logic sync_in,
    input  logic hd_in,
    output logic cs_evt_o,
    output logic vd_evt_o,
    output logic vd_odd_o,
    output logic hd_active_o
);
    localparam int CW = $clog2(VR_MIN_CLK + 1);
    localparam logic [CW-1:0] VR_MIN = CW'(VR_MIN_CLK);

    typedef struct packed {
        logic [1:0]    sy_pipe;
        logic          sy_prev;
        logic [1:0]    hd_pipe;
        logic          hd_prev;
        logic [CW-1:0] low_clks;
        logic [1:0]    hi_lines;
        logic [1:0]    hd_age;
        logic          cs_evt;
        logic          vd_evt;
        logic          vd_odd;
    } probe_t;

    probe_t q, d;
    logic sy, sy_rise, sy_fall, hd_rise;

    always_comb begin
        d        = q;
        d.cs_evt = 1'b0;
        d.vd_evt = 1'b0;

        d.sy_pipe = {q.sy_pipe[0], sync_in};
        d.sy_prev = q.sy_pipe[1];
        d.hd_pipe = {q.hd_pipe[0], hd_in};
        d.hd_prev = q.hd_pipe[1];

        sy      = q.sy_pipe[1];
        sy_rise = sy & ~q.sy_prev;
        sy_fall = ~sy & q.sy_prev;
        hd_rise = q.hd_pipe[1] & ~q.hd_prev;

        // Composite: length of the current low phase, saturating at threshold
        if (sy) begin
            d.low_clks = '0;
        end else if (q.low_clks != VR_MIN) begin
            d.low_clks = q.low_clks + 1'b1;
        end
        if (sy_rise && (q.low_clks == VR_MIN)) begin
            d.cs_evt = 1'b1;
        end

        // Separate drive: width of the high phase in line ticks
        if (!sy) begin
            d.hi_lines = '0;
        end else if (line_tick && (q.hi_lines != 2'd3)) begin
            d.hi_lines = q.hi_lines + 1'b1;
        end
        if (sy_fall && (q.hi_lines >= 2'd2)) begin
            d.vd_evt = 1'b1;
            d.vd_odd = ~line_half;
        end

        // HD activity: lines since the last HD rising edge
        if (hd_rise) begin
            d.hd_age = '0;
        end else if (line_tick && (q.hd_age != 2'd3)) begin
            d.hd_age = q.hd_age + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.hd_age <= 2'd3;
        end else begin
            q <= d;
        end
    end

    assign cs_evt_o    = q.cs_evt;
    assign vd_evt_o    = q.vd_evt;
    assign vd_odd_o    = q.vd_odd;
    assign hd_active_o = (q.hd_age < 2'd2);

    AST_EVT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({q.cs_evt, q.vd_evt})); // R4

endmodule

// File: rtl/vsm_mode_ctl.sv
// Sync source selection and loss-of-reference timeout.
module vsm_mode_ctl
    import vsm_pkg::*;
#(
    parameter int FRAME_525 = 525,
    parameter int FRAME_625 = 625
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_tick,
    input  logic std_625,
    input  logic sync_sel,
    input  logic cs_evt,
    input  logic vd_evt,
    input  logic hd_active,
    output logic apply_cs_o,
    output logic apply_vd_o,
    output logic ext_o
);
    localparam int IW = $clog2(FRAME_625 + 1);

    typedef struct packed {
        vsm_mode_e     mode;
        logic [IW-1:0] idle;
    } mode_t;

    mode_t q, d;
    logic  take_cs, take_vd;
    logic [IW-1:0] idle_lim;

    always_comb begin
        d        = q;
        take_cs  = cs_evt & ~sync_sel;
        take_vd  = vd_evt & sync_sel & hd_active;
        idle_lim = std_625 ? IW'(FRAME_625 - 1) : IW'(FRAME_525 - 1);

        if (take_vd) begin
            d.mode = VSM_VDHD;
            d.idle = '0;
        end else if (take_cs) begin
            d.mode = VSM_CSYNC;
            d.idle = '0;
        end else if (line_tick) begin
            if (q.idle >= idle_lim) begin
                d.mode = VSM_INT;
            end else begin
                d.idle = q.idle + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.mode <= VSM_INT;
            q.idle <= '0;
        end else begin
            q <= d;
        end
    end

    assign apply_cs_o = take_cs;
    assign apply_vd_o = take_vd;
    assign ext_o      = (q.mode != VSM_INT);

    AST_EXT_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ext_o) |-> $past(cs_evt || vd_evt)); // R7

    AST_DROP_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ext_o) |-> $past(line_tick)); // R8

endmodule

// File: rtl/vsm_vert_gen.sv
// Field line counter with pending vertical reset and field parity.
module vsm_vert_gen #(
    parameter int FRAME_525  = 525,
    parameter int FRAME_625  = 625,
    parameter int CS_DLY_525 = 259,
    parameter int CS_DLY_625 = 309,
    parameter int VD_W_LINES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_tick,
    input  logic std_625,
    input  logic apply_cs,
    input  logic apply_vd,
    input  logic vd_odd,
    output logic vd_n_o,
    output logic field_odd_o
);
    localparam int LW      = $clog2(FRAME_625 + 1);
    localparam int PW      = $clog2(CS_DLY_625 + 1);
    localparam int ODD_525 = (FRAME_525 + 1) / 2;
    localparam int EVN_525 = FRAME_525 / 2;
    localparam int ODD_625 = (FRAME_625 + 1) / 2;
    localparam int EVN_625 = FRAME_625 / 2;

    typedef struct packed {
        logic [LW-1:0] line_cnt;
        logic          field_odd;
        logic          pend_act;
        logic [PW-1:0] pend_cnt;
        logic          pend_fset;
        logic          pend_field;
    } vert_t;

    vert_t q, d;
    logic [LW-1:0] len_now;

    always_comb begin
        d = q;
        if (q.field_odd) begin
            len_now = std_625 ? LW'(ODD_625) : LW'(ODD_525);
        end else begin
            len_now = std_625 ? LW'(EVN_625) : LW'(EVN_525);
        end

        if (line_tick) begin
            if (q.pend_act && (q.pend_cnt == PW'(1))) begin
                d.line_cnt = '0;
                d.pend_act = 1'b0;
                if (q.pend_fset) begin
                    d.field_odd = q.pend_field;
                end
            end else begin
                if (q.pend_act) begin
                    d.pend_cnt = q.pend_cnt - 1'b1;
                end
                if (q.line_cnt >= len_now - 1'b1) begin
                    d.line_cnt  = '0;
                    d.field_odd = ~q.field_odd;
                end else begin
                    d.line_cnt = q.line_cnt + 1'b1;
                end
            end
        end

        if (apply_cs) begin
            d.pend_act  = 1'b1;
            d.pend_cnt  = std_625 ? PW'(CS_DLY_625) : PW'(CS_DLY_525);
            d.pend_fset = 1'b0;
        end else if (apply_vd) begin
            d.pend_act   = 1'b1;
            d.pend_cnt   = PW'(1);
            d.pend_fset  = 1'b1;
            d.pend_field = vd_odd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q           <= '0;
            q.field_odd <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign vd_n_o      = (q.line_cnt >= LW'(VD_W_LINES));
    assign field_odd_o = q.field_odd;

    AST_CNT_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(line_tick) |-> $stable(q.line_cnt)); // R2

    AST_FIELD_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.field_odd) |-> (q.line_cnt == '0)); // R6

    AST_PEND_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        q.pend_act |-> (q.pend_cnt != '0)); // R3

endmodule

// File: rtl/vsm_top.sv
module vsm_top #(
    parameter int VR_MIN_CLK = 400,
    parameter int FRAME_525  = 525,
    parameter int FRAME_625  = 625,
    parameter int CS_DLY_525 = 259,
    parameter int CS_DLY_625 = 309,
    parameter int VD_W_LINES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_tick,
    input  logic line_half,
    input  logic sync_in,
    input  logic hd_in,
    input  logic sync_sel,
    input  logic std_625,
    output logic ext_sync_o,
    output logic vd_n_o,
    output logic field_odd_o
);
    logic cs_evt, vd_evt, vd_odd, hd_active;
    logic apply_cs, apply_vd;

    vsm_sync_probe #(
        .VR_MIN_CLK (VR_MIN_CLK)
    ) i_probe (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_tick   (line_tick),
        .line_half   (line_half),
        .sync_in     (sync_in),
        .hd_in       (hd_in),
        .cs_evt_o    (cs_evt),
        .vd_evt_o    (vd_evt),
        .vd_odd_o    (vd_odd),
        .hd_active_o (hd_active)
    );

    vsm_mode_ctl #(
        .FRAME_525 (FRAME_525),
        .FRAME_625 (FRAME_625)
    ) i_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_tick  (line_tick),
        .std_625    (std_625),
        .sync_sel   (sync_sel),
        .cs_evt     (cs_evt),
        .vd_evt     (vd_evt),
        .hd_active  (hd_active),
        .apply_cs_o (apply_cs),
        .apply_vd_o (apply_vd),
        .ext_o      (ext_sync_o)
    );

    vsm_vert_gen #(
        .FRAME_525  (FRAME_525),
        .FRAME_625  (FRAME_625),
        .CS_DLY_525 (CS_DLY_525),
        .CS_DLY_625 (CS_DLY_625),
        .VD_W_LINES (VD_W_LINES)
    ) i_vert (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_tick   (line_tick),
        .std_625     (std_625),
        .apply_cs    (apply_cs),
        .apply_vd    (apply_vd),
        .vd_odd      (vd_odd),
        .vd_n_o      (vd_n_o),
        .field_odd_o (field_odd_o)
    );

endmodule

// File: tb/test_vsm_top.sv
`timescale 1ns/1ps
module test_vsm_top;
    localparam int LP = 10;   // clocks per line

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_tick = 1'b0, line_half = 1'b0, sync_in = 1'b0, hd_in = 1'b0;
    logic sync_sel = 1'b0, std_625 = 1'b0;
    logic ext_sync_o, vd_n_o, field_odd_o;
    logic hd_en = 1'b0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    vsm_top #(.VR_MIN_CLK(20)) i_vsm_top (
        .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .line_half(line_half),
        .sync_in(sync_in), .hd_in(hd_in), .sync_sel(sync_sel), .std_625(std_625),
        .ext_sync_o(ext_sync_o), .vd_n_o(vd_n_o), .field_odd_o(field_odd_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_lines(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            line_tick = 1'b1;
            if (hd_en) hd_in = 1'b1;
            @(negedge clk);
            line_tick = 1'b0;
            repeat (3) @(negedge clk);
            hd_in = 1'b0;
            repeat (LP - 5) @(negedge clk);
        end
    endtask

    task automatic settle();
        repeat (8) @(negedge clk);
    endtask

    task automatic do_reset(input logic std, input logic sel, input logic idle_sync);
        @(negedge clk);
        rst_n = 1'b0;
        std_625 = std; sync_sel = sel; sync_in = idle_sync;
        hd_in = 1'b0; line_half = 1'b0; line_tick = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // R1, R2: reset state and free-running interlace
    task automatic t_internal();
        do_reset(1'b0, 1'b0, 1'b1);
        chk("R1 ext", ext_sync_o, 0);
        chk("R1 vd_n", vd_n_o, 0);
        chk("R1 field", field_odd_o, 1);
        run_lines(3);
        chk("R2 vd_n after width", vd_n_o, 1);
        run_lines(259);
        chk("R2 odd525 line262 vd_n", vd_n_o, 1);
        chk("R2 odd525 line262 field", field_odd_o, 1);
        run_lines(1);
        chk("R2 even525 start vd_n", vd_n_o, 0);
        chk("R2 even525 start field", field_odd_o, 0);
        run_lines(261);
        chk("R2 even525 end vd_n", vd_n_o, 1);
        run_lines(1);
        chk("R2 odd525 restart field", field_odd_o, 1);
        chk("R2 odd525 restart vd_n", vd_n_o, 0);
        do_reset(1'b1, 1'b0, 1'b1);
        run_lines(312);
        chk("R2 odd625 line312 vd_n", vd_n_o, 1);
        run_lines(1);
        chk("R2 even625 start vd_n", vd_n_o, 0);
        chk("R2 even625 start field", field_odd_o, 0);
    endtask

    // R3, R7, R8: composite sync restart and timeout
    task automatic t_csync(input logic std);
        int dly, frame;
        dly = std ? 309 : 259;
        frame = std ? 625 : 525;
        do_reset(std, 1'b0, 1'b1);
        settle();
        sync_in = 1'b0; repeat (2) @(negedge clk); sync_in = 1'b1;
        settle();
        chk("R3 short low ignored", ext_sync_o, 0);
        sync_in = 1'b0; repeat (30) @(negedge clk); sync_in = 1'b1;
        settle();
        chk("R7 ext after composite", ext_sync_o, 1);
        run_lines(dly - 1);
        chk("R3 before restart vd_n", vd_n_o, 1);
        run_lines(1);
        chk("R3 restart vd_n", vd_n_o, 0);
        chk("R3 field kept", field_odd_o, 1);
        run_lines(frame - 1 - dly);
        chk("R8 still external", ext_sync_o, 1);
        run_lines(1);
        chk("R8 timeout to internal", ext_sync_o, 0);
    endtask

    task automatic vd_pulse(input logic half);
        sync_in = 1'b1;
        settle();
        run_lines(2);
        line_half = half;
        sync_in = 1'b0;
        settle();
    endtask

    // R4, R5, R6, R7, R9: separate-drive lock
    task automatic t_vdhd();
        do_reset(1'b0, 1'b1, 1'b0);
        hd_en = 1'b1;
        run_lines(5);
        vd_pulse(1'b0);
        chk("R7 ext after vd", ext_sync_o, 1);
        chk("R4 before restart vd_n", vd_n_o, 1);
        run_lines(1);
        chk("R4 restart vd_n", vd_n_o, 0);
        chk("R6 first half odd", field_odd_o, 1);
        run_lines(20);
        vd_pulse(1'b1);
        run_lines(1);
        chk("R4 second restart vd_n", vd_n_o, 0);
        chk("R6 second half even", field_odd_o, 0);
        run_lines(10);
        sync_in = 1'b1;
        settle();
        run_lines(1);
        sync_in = 1'b0;
        settle();
        run_lines(1);
        chk("R5 short pulse ignored", vd_n_o, 1);
        run_lines(400);
        chk("R9 lock held", ext_sync_o, 1);
        vd_pulse(1'b1);
        chk("R9 before restart vd_n", vd_n_o, 1);
        run_lines(1);
        chk("R9 restart vd_n", vd_n_o, 0);
        chk("R9 field even", field_odd_o, 0);
        chk("R9 ext", ext_sync_o, 1);
        hd_en = 1'b0;
    endtask

    // R10: no HD means no separate-drive lock
    task automatic t_nohd();
        do_reset(1'b0, 1'b1, 1'b0);
        hd_en = 1'b0;
        run_lines(5);
        vd_pulse(1'b0);
        chk("R10 ext stays low", ext_sync_o, 0);
        run_lines(1);
        chk("R10 no restart vd_n", vd_n_o, 1);
    endtask

    initial begin
        t_internal();
        t_csync(1'b0);
        t_csync(1'b1);
        t_vdhd();
        t_nohd();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule